// File: doc/BRIEF.md
# Selectable Multi-Element Power Accumulator

This block sums real power and squared current for each metering element of an energy meter. Each element has its own sums. A 3-bit wiring code selects one of six wiring arrangements. The code picks which voltage and current samples feed up to three elements. Some arrangements feed an element with the difference of two phase currents, and they halve that difference before the multiply.

Each accepted sample strobe carries six signed samples: three voltages and three currents. Every active element adds its voltage-times-current product to a power sum and adds the square of its current to a current-squared sum. The period length is a number of samples per cycle times a number of cycles per period. When the period ends, the block copies the per-element totals and their grand total to the output registers. It also pulses a one-clock done flag and clears the running sums, so the next period starts from zero.

The enable input, the wiring code and the two length values are taken only at a period boundary. Software can therefore change them at any time without corrupting the period in progress.

Top module: `power_accum_top`

## Requirements
- R1: Code 0: element 0 power is VA*IA, and its current-squared term is IA*IA.
- R2: Code 1: element 0 power is VA*H and its current-squared term is D*D, where D = IA-IB. H is D shifted right arithmetically by one (floor of D/2), so VA=1000, IA=-3, IB=0 gives power -2000 and current-squared 9.
- R3: Code 2: element 0 is VA*IA with current IA, and element 1 is VB*IB with current IB.
- R4: Code 3: element 0 is VA*floor((IA-IB)/2) with current IA-IB, and element 1 is VC*IC with current IC.
- R5: Code 4: element 0 is VA*floor((IA-IB)/2) with current IA-IB, and element 1 is VB*floor((IC-IB)/2) with current IC-IB.
- R6: Code 5 uses three elements: VA*IA, VB*IB and VC*IC, with currents IA, IB and IC. Codes 6 and 7 behave exactly as code 5.
- R7: Elements not used by the active code report zero for both power and current-squared.
- R8: The total power output equals the sum of the three element power outputs, taken modulo 2^ACC_W.
- R9: A period holds S*C accepted samples, where S is the samples-per-cycle value and C is the cycles-per-period value. A value of 0 in either field counts as 1.
- R10: done_o is high for exactly one clock after the last sample of a period. The result outputs change only on that clock and hold until the next one. Each period's sums begin at zero.
- R11: Enable is examined only when no period is running and at each period boundary. Strobes while idle are ignored. Dropping enable mid-period lets the current period finish, and after that no further done pulse occurs.
- R12: A change of the wiring code or the length values during a period takes effect only for the following period.
- R13: During and right after reset, done_o is low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable, examined at period boundaries |
| equ_sel | input | 3 | Wiring code 0..7 |
| spc_cfg | input | SPC_W | Samples per cycle (0 counts as 1) |
| cpp_cfg | input | CPP_W | Cycles per period (0 counts as 1) |
| smp_valid | input | 1 | Sample strobe |
| va_i | input | SAMPLE_W | Voltage A, signed |
| vb_i | input | SAMPLE_W | Voltage B, signed |
| vc_i | input | SAMPLE_W | Voltage C, signed |
| ia_i | input | SAMPLE_W | Current A, signed |
| ib_i | input | SAMPLE_W | Current B, signed |
| ic_i | input | SAMPLE_W | Current C, signed |
| done_o | output | 1 | One-clock end-of-period pulse |
| pwr0_o | output | ACC_W | Element 0 power sum |
| pwr1_o | output | ACC_W | Element 1 power sum |
| pwr2_o | output | ACC_W | Element 2 power sum |
| isq0_o | output | ACC_W | Element 0 current-squared sum |
| isq1_o | output | ACC_W | Element 1 current-squared sum |
| isq2_o | output | ACC_W | Element 2 current-squared sum |
| pwr_tot_o | output | ACC_W | Sum of element power sums |

## Verification
The bench runs one period under every wiring code 0 to 7, using pseudo-random signed samples that include negative values. A wrong routing, a missing halving or a swapped difference shows up as a mismatch in a specific element's sum. A one-sample period with an odd negative difference separates an arithmetic shift from division rounding toward zero.

Period lengths of 1, 2, 4, 5 and 6 samples, some with zero fields, check the length decode. Strobes with idle gaps check that only valid strobes are counted. Each period's wiring code is changed mid-period to show the change is deferred to the next boundary. The last run drops enable mid-period and then sends more strobes, to confirm the period finishes and no later done pulse appears.

// File: rtl/power_accum_pkg.sv
package power_accum_pkg;

  localparam int NUM_ELEM = 3;

  typedef enum logic [2:0] {
    WIRE_1E_2W       = 3'd0,
    WIRE_1E_3W       = 3'd1,
    WIRE_2E_3W_DELTA = 3'd2,
    WIRE_2E_4W_DELTA = 3'd3,
    WIRE_2E_4W_WYE   = 3'd4,
    WIRE_3E_4W_WYE   = 3'd5
  } wiring_e;

  // Codes above the last defined arrangement fold onto the three-element one.
  function automatic wiring_e norm_wiring(input logic [2:0] code);
    wiring_e w;
    case (code)
      3'd0: w = WIRE_1E_2W;
      3'd1: w = WIRE_1E_3W;
      3'd2: w = WIRE_2E_3W_DELTA;
      3'd3: w = WIRE_2E_4W_DELTA;
      3'd4: w = WIRE_2E_4W_WYE;
      default: w = WIRE_3E_4W_WYE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/power_elem_route.sv
module power_elem_route
  import power_accum_pkg::*;
#(
  parameter int SW = 16
) (
  input  wiring_e                 wiring,
  input  logic signed [SW-1:0]    va,
  input  logic signed [SW-1:0]    vb,
  input  logic signed [SW-1:0]    vc,
  input  logic signed [SW-1:0]    ia,
  input  logic signed [SW-1:0]    ib,
  input  logic signed [SW-1:0]    ic,
  output logic signed [SW-1:0]    v_o  [NUM_ELEM],
  output logic signed [SW:0]      ip_o [NUM_ELEM],
  output logic signed [SW:0]      iq_o [NUM_ELEM]
);

  localparam int DW = SW + 1;

  logic signed [DW-1:0] ia_x, ib_x, ic_x;
  logic signed [DW-1:0] d_ab, d_cb, h_ab, h_cb;

  assign ia_x = DW'(ia);
  assign ib_x = DW'(ib);
  assign ic_x = DW'(ic);
  assign d_ab = ia_x - ib_x;
  assign d_cb = ic_x - ib_x;
  // Floor halving of the difference before it reaches the multiplier.
  assign h_ab = d_ab >>> 1;
  assign h_cb = d_cb >>> 1;

  always_comb begin
    for (int e = 0; e < NUM_ELEM; e++) begin
      v_o[e]  = '0;
      ip_o[e] = '0;
      iq_o[e] = '0;
    end
    case (wiring)
      WIRE_1E_2W: begin
        v_o[0] = va; ip_o[0] = ia_x; iq_o[0] = ia_x;
      end
      WIRE_1E_3W: begin
        v_o[0] = va; ip_o[0] = h_ab; iq_o[0] = d_ab;
      end
      WIRE_2E_3W_DELTA: begin
        v_o[0] = va; ip_o[0] = ia_x; iq_o[0] = ia_x;
        v_o[1] = vb; ip_o[1] = ib_x; iq_o[1] = ib_x;
      end
      WIRE_2E_4W_DELTA: begin
        v_o[0] = va; ip_o[0] = h_ab; iq_o[0] = d_ab;
        v_o[1] = vc; ip_o[1] = ic_x; iq_o[1] = ic_x;
      end
      WIRE_2E_4W_WYE: begin
        v_o[0] = va; ip_o[0] = h_ab; iq_o[0] = d_ab;
        v_o[1] = vb; ip_o[1] = h_cb; iq_o[1] = d_cb;
      end
      default: begin
        v_o[0] = va; ip_o[0] = ia_x; iq_o[0] = ia_x;
        v_o[1] = vb; ip_o[1] = ib_x; iq_o[1] = ib_x;
        v_o[2] = vc; ip_o[2] = ic_x; iq_o[2] = ic_x;
      end
    endcase
  end

endmodule

// File: rtl/power_period_ctl.sv
module power_period_ctl
  import power_accum_pkg::*;
#(
  parameter int SPC_W = 8,
  parameter int CPP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       equ_in,
  input  logic [SPC_W-1:0] spc_in,
  input  logic [CPP_W-1:0] cpp_in,
  input  logic             smp_valid,
  output logic             accept_o,
  output logic             last_o,
  output logic             done_o,
  output wiring_e          wiring_o
);

  logic             run_q;
  logic [SPC_W-1:0] smp_idx, smp_lim;
  logic [CPP_W-1:0] cyc_idx, cyc_lim;
  wiring_e          wiring_q;
  logic             done_q;
  logic             at_cyc_end;

  assign accept_o   = run_q & smp_valid;
  assign at_cyc_end = (smp_idx == smp_lim);
  assign last_o     = accept_o & at_cyc_end & (cyc_idx == cyc_lim);
  assign done_o     = done_q;
  assign wiring_o   = wiring_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      smp_idx  <= '0;
      cyc_idx  <= '0;
      smp_lim  <= '0;
      cyc_lim  <= '0;
      wiring_q <= WIRE_1E_2W;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_o;
      if (!run_q || last_o) begin
        // Period boundary: the only place configuration is taken.
        if (!run_q) run_q <= en;
        else        run_q <= en;
        smp_lim  <= (spc_in == '0) ? '0 : spc_in - 1'b1;
        cyc_lim  <= (cpp_in == '0) ? '0 : cpp_in - 1'b1;
        wiring_q <= norm_wiring(equ_in);
        smp_idx  <= '0;
        cyc_idx  <= '0;
      end else if (accept_o) begin
        if (at_cyc_end) begin
          smp_idx <= '0;
          cyc_idx <= cyc_idx + 1'b1;
        end else begin
          smp_idx <= smp_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/power_elem_mac.sv
module power_elem_mac #(
  parameter int SW = 16,
  parameter int AW = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 last,
  input  logic signed [SW-1:0] v_i,
  input  logic signed [SW:0]   ip_i,
  input  logic signed [SW:0]   iq_i,
  output logic signed [AW-1:0] pwr_next_o,
  output logic signed [AW-1:0] pwr_o,
  output logic signed [AW-1:0] isq_o
);

  localparam int PW = 2 * SW + 1;
  localparam int QW = 2 * SW + 2;

  logic signed [PW-1:0] prod;
  logic signed [QW-1:0] sq;
  logic signed [AW-1:0] prod_x, sq_x;
  logic signed [AW-1:0] acc_p, acc_q;
  logic signed [AW-1:0] isq_next;

  assign prod       = v_i * ip_i;
  assign sq         = iq_i * iq_i;
  assign prod_x     = {{(AW-PW){prod[PW-1]}}, prod};
  assign sq_x       = {{(AW-QW){sq[QW-1]}}, sq};
  assign pwr_next_o = acc_p + prod_x;
  assign isq_next   = acc_q + sq_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_p <= '0;
      acc_q <= '0;
      pwr_o <= '0;
      isq_o <= '0;
    end else if (accept) begin
      if (last) begin
        pwr_o <= pwr_next_o;
        isq_o <= isq_next;
        acc_p <= '0;
        acc_q <= '0;
      end else begin
        acc_p <= pwr_next_o;
        acc_q <= isq_next;
      end
    end
  end

endmodule

// File: rtl/power_accum_top.sv
module power_accum_top
  import power_accum_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 48,
  parameter int SPC_W    = 8,
  parameter int CPP_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [2:0]              equ_sel,
  input  logic [SPC_W-1:0]        spc_cfg,
  input  logic [CPP_W-1:0]        cpp_cfg,
  input  logic                    smp_valid,
  input  logic signed [SAMPLE_W-1:0] va_i,
  input  logic signed [SAMPLE_W-1:0] vb_i,
  input  logic signed [SAMPLE_W-1:0] vc_i,
  input  logic signed [SAMPLE_W-1:0] ia_i,
  input  logic signed [SAMPLE_W-1:0] ib_i,
  input  logic signed [SAMPLE_W-1:0] ic_i,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] pwr0_o,
  output logic signed [ACC_W-1:0] pwr1_o,
  output logic signed [ACC_W-1:0] pwr2_o,
  output logic signed [ACC_W-1:0] isq0_o,
  output logic signed [ACC_W-1:0] isq1_o,
  output logic signed [ACC_W-1:0] isq2_o,
  output logic signed [ACC_W-1:0] pwr_tot_o
);

  logic    accept, last;
  wiring_e wiring;

  logic signed [SAMPLE_W-1:0] el_v  [NUM_ELEM];
  logic signed [SAMPLE_W:0]   el_ip [NUM_ELEM];
  logic signed [SAMPLE_W:0]   el_iq [NUM_ELEM];
  logic signed [ACC_W-1:0]    el_pnext [NUM_ELEM];
  logic signed [ACC_W-1:0]    el_pwr   [NUM_ELEM];
  logic signed [ACC_W-1:0]    el_isq   [NUM_ELEM];
  logic signed [ACC_W-1:0]    tot_next;
  logic signed [ACC_W-1:0]    tot_q;

  power_period_ctl #(.SPC_W(SPC_W), .CPP_W(CPP_W)) ctl_i (
    .clk(clk), .rst(rst), .en(en), .equ_in(equ_sel),
    .spc_in(spc_cfg), .cpp_in(cpp_cfg), .smp_valid(smp_valid),
    .accept_o(accept), .last_o(last), .done_o(done_o), .wiring_o(wiring)
  );

  power_elem_route #(.SW(SAMPLE_W)) route_i (
    .wiring(wiring), .va(va_i), .vb(vb_i), .vc(vc_i),
    .ia(ia_i), .ib(ib_i), .ic(ic_i),
    .v_o(el_v), .ip_o(el_ip), .iq_o(el_iq)
  );

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    power_elem_mac #(.SW(SAMPLE_W), .AW(ACC_W)) mac_i (
      .clk(clk), .rst(rst), .accept(accept), .last(last),
      .v_i(el_v[e]), .ip_i(el_ip[e]), .iq_i(el_iq[e]),
      .pwr_next_o(el_pnext[e]), .pwr_o(el_pwr[e]), .isq_o(el_isq[e])
    );
  end

  always_comb begin
    tot_next = '0;
    for (int e = 0; e < NUM_ELEM; e++) tot_next = tot_next + el_pnext[e];
  end

  always_ff @(posedge clk) begin
    if (rst)              tot_q <= '0;
    else if (last)        tot_q <= tot_next;
  end

  assign pwr0_o    = el_pwr[0];
  assign pwr1_o    = el_pwr[1];
  assign pwr2_o    = el_pwr[2];
  assign isq0_o    = el_isq[0];
  assign isq1_o    = el_isq[1];
  assign isq2_o    = el_isq[2];
  assign pwr_tot_o = tot_q;

endmodule

// File: rtl/power_accum_chk.sv
module power_accum_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic          accept,
  input logic          done,
  input logic [2:0]    wiring,
  input logic [AW-1:0] pwr0,
  input logic [AW-1:0] pwr1,
  input logic [AW-1:0] pwr2,
  input logic [AW-1:0] isq0,
  input logic [AW-1:0] isq1,
  input logic [AW-1:0] isq2,
  input logic [AW-1:0] tot
);

  // R10: a done pulse follows an accepted strobe
  p_done_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(accept));

  // R11: without a strobe there is no done
  p_no_strobe_no_done_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_valid) |-> !done);

  // R10: results hold between done pulses
  p_hold_results_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pwr0) && $stable(pwr1) && $stable(pwr2) &&
               $stable(isq0) && $stable(isq1) && $stable(isq2) && $stable(tot)));

  // R8: total tracks the element sums
  p_total_sum_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (tot == AW'(pwr0 + pwr1 + pwr2)));

  // R7: single-element codes leave elements 1 and 2 at zero
  p_unused_one_r7: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(wiring) <= 3'd1)) |->
      (pwr1 == '0 && pwr2 == '0 && isq1 == '0 && isq2 == '0));

  // R7: two-element codes leave element 2 at zero
  p_unused_two_r7: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(wiring) <= 3'd4)) |-> (pwr2 == '0 && isq2 == '0));

endmodule

bind power_accum_top power_accum_chk #(.AW(ACC_W)) chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .accept(accept),
  .done(done_o), .wiring(wiring),
  .pwr0(pwr0_o), .pwr1(pwr1_o), .pwr2(pwr2_o),
  .isq0(isq0_o), .isq1(isq1_o), .isq2(isq2_o), .tot(pwr_tot_o)
);

// File: tb/power_accum_top_tb_top.sv
module power_accum_top_tb_top;

  localparam int SW = 16;
  localparam int AW = 48;

  typedef struct {
    longint p [3];
    longint q [3];
    int     nact;
    string  req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [2:0] equ_sel = '0;
  logic [7:0] spc_cfg = 8'd1;
  logic [7:0] cpp_cfg = 8'd1;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] va = '0, vb = '0, vc = '0, ia = '0, ib = '0, ic = '0;
  logic done;
  logic signed [AW-1:0] pwr0, pwr1, pwr2, isq0, isq1, isq2, ptot;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  bit [31:0] lcg = 32'h1234_5678;
  exp_t exp_q [$];
  exp_t last_exp;
  longint m_p [3];
  longint m_q [3];

  always #2 clk = ~clk;

  power_accum_top dut_i (
    .clk(clk), .rst(rst), .en(en), .equ_sel(equ_sel),
    .spc_cfg(spc_cfg), .cpp_cfg(cpp_cfg), .smp_valid(smp_valid),
    .va_i(va), .vb_i(vb), .vc_i(vc), .ia_i(ia), .ib_i(ib), .ic_i(ic),
    .done_o(done), .pwr0_o(pwr0), .pwr1_o(pwr1), .pwr2_o(pwr2),
    .isq0_o(isq0), .isq1_o(isq1), .isq2_o(isq2), .pwr_tot_o(ptot)
  );

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    logic [AW-1:0] a, x;
    a = AW'(act);
    x = AW'(expv);
    checks++;
    if (a !== x) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic signed [SW-1:0] rnd16();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31:16];
  endfunction

  // Reference per requirements R1..R6 (halving is floor division by two).
  task automatic model_add(input int code, input longint a, input longint b, input longint c,
                           input longint x, input longint y, input longint z, output int nact);
    longint dab, dcb;
    dab = x - y;
    dcb = z - y;
    if (code > 5) code = 5;
    case (code)
      0: begin m_p[0] += a * x; m_q[0] += x * x; nact = 1; end
      1: begin m_p[0] += a * (dab >>> 1); m_q[0] += dab * dab; nact = 1; end
      2: begin m_p[0] += a * x; m_q[0] += x * x;
               m_p[1] += b * y; m_q[1] += y * y; nact = 2; end
      3: begin m_p[0] += a * (dab >>> 1); m_q[0] += dab * dab;
               m_p[1] += c * z; m_q[1] += z * z; nact = 2; end
      4: begin m_p[0] += a * (dab >>> 1); m_q[0] += dab * dab;
               m_p[1] += b * (dcb >>> 1); m_q[1] += dcb * dcb; nact = 2; end
      default: begin m_p[0] += a * x; m_q[0] += x * x;
               m_p[1] += b * y; m_q[1] += y * y;
               m_p[2] += c * z; m_q[2] += z * z; nact = 3; end
    endcase
  endtask

  task automatic put(input logic signed [SW-1:0] a, b, c, x, y, z);
    va = a; vb = b; vc = c; ia = x; ib = y; ic = z;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // Driver: one period under the latched code; next config applied mid-period (R12).
  task automatic run_period(input int code, input int n, input int nxt_code,
                            input int nxt_spc, input int nxt_cpp, input bit gaps,
                            input bit drop_en, input bit fixed, input string req);
    exp_t e;
    int na;
    for (int k = 0; k < 3; k++) begin m_p[k] = 0; m_q[k] = 0; end
    na = 0;
    for (int k = 0; k < n; k++) begin
      logic signed [SW-1:0] a, b, c, x, y, z;
      if (fixed) begin
        a = 16'sd1000; b = 16'sd7; c = 16'sd9; x = -16'sd3; y = 16'sd0; z = 16'sd5;
      end else begin
        a = rnd16(); b = rnd16(); c = rnd16(); x = rnd16(); y = rnd16(); z = rnd16();
      end
      if (k == n - 1) begin
        equ_sel = 3'(nxt_code);
        spc_cfg = 8'(nxt_spc);
        cpp_cfg = 8'(nxt_cpp);
        if (drop_en) en = 1'b0;
      end else if (k == 0) begin
        equ_sel = 3'(code ^ 3);
        spc_cfg = 8'd0;
      end
      model_add(code, a, b, c, x, y, z, na);
      if (k == n - 1) begin
        e.p = m_p; e.q = m_q; e.nact = na; e.req = req;
        exp_q.push_back(e);
      end
      put(a, b, c, x, y, z);
      if (gaps && (k % 2 == 1)) @(negedge clk);
    end
  endtask

  // Monitor: pops expected results on each done pulse.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        longint tot;
        e = exp_q.pop_front();
        last_exp = e;
        tot = e.p[0] + e.p[1] + e.p[2];
        chk(e.req, "pwr0", pwr0, e.p[0]);
        chk(e.nact > 1 ? e.req : "R7", "pwr1", pwr1, e.p[1]);
        chk(e.nact > 2 ? e.req : "R7", "pwr2", pwr2, e.p[2]);
        chk(e.req, "isq0", isq0, e.q[0]);
        chk(e.nact > 1 ? e.req : "R7", "isq1", isq1, e.q[1]);
        chk(e.nact > 2 ? e.req : "R7", "isq2", isq2, e.q[2]);
        chk("R8", "total", ptot, tot);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R13: reset state
    chk("R13", "done in reset", done, 0);
    chk("R13", "pwr0 in reset", pwr0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R13", "done after reset", done, 0);
    chk("R13", "total after reset", ptot, 0);
    chk("R13", "isq2 after reset", isq2, 0);

    // R11: strobes while idle are ignored
    put(16'sd100, 16'sd1, 16'sd1, 16'sd100, 16'sd1, 16'sd1);
    put(16'sd100, 16'sd1, 16'sd1, 16'sd100, 16'sd1, 16'sd1);
    repeat (3) @(negedge clk);
    chk("R11", "pwr0 after idle strobes", pwr0, 0);

    equ_sel = 3'd0; spc_cfg = 8'd2; cpp_cfg = 8'd3; en = 1'b1;
    @(negedge clk);
    run_period(0, 6, 1, 1, 1, 1'b0, 1'b0, 1'b0, "R1 R9 R12");
    run_period(1, 1, 2, 3, 2, 1'b0, 1'b0, 1'b1, "R2");
    run_period(2, 6, 3, 0, 4, 1'b1, 1'b0, 1'b0, "R3 R10");
    run_period(3, 4, 4, 2, 2, 1'b0, 1'b0, 1'b0, "R4 R9");
    run_period(4, 4, 5, 5, 1, 1'b1, 1'b0, 1'b0, "R5");
    run_period(5, 5, 6, 1, 3, 1'b0, 1'b0, 1'b0, "R6");
    run_period(6, 3, 7, 2, 0, 1'b0, 1'b0, 1'b0, "R6 R9");
    run_period(7, 2, 0, 1, 1, 1'b0, 1'b0, 1'b0, "R6");
    run_period(0, 1, 1, 1, 1, 1'b0, 1'b0, 1'b0, "R1 R10");
    run_period(1, 1, 5, 3, 1, 1'b0, 1'b0, 1'b0, "R2 R10");
    run_period(5, 3, 0, 1, 1, 1'b0, 1'b1, 1'b0, "R11");
    repeat (2) @(negedge clk);
    chk("R10", "queue drained", exp_q.size(), 0);

    // R11: enable dropped, further strobes give no done; R10: results hold
    put(16'sd5, 16'sd5, 16'sd5, 16'sd5, 16'sd5, 16'sd5);
    put(16'sd5, 16'sd5, 16'sd5, 16'sd5, 16'sd5, 16'sd5);
    repeat (6) @(negedge clk);
    chk("R10", "pwr0 held", pwr0, last_exp.p[0]);
    chk("R10", "isq2 held", isq2, last_exp.q[2]);
    chk("R11", "done low after disable", done, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule